// File: doc/BRIEF.md
# Word-Mapped Serial Port with Event Pulses

This block is a small serial port that a processor reaches through two 32-bit word registers. One word carries the data in both directions. A store to it sends the byte in the low eight bits of the store on the transmit line. A load from it returns the byte that arrived most recently on the receive line. The second word holds a divisor, and the divisor sets how long each bit lasts on both serial lines.

The block has no status word and no queue. Software learns about progress only from two interrupt lines, and each gives a single-clock pulse. One pulses when a sent byte has fully left the line, including its stop bit. The other pulses when a received byte has been placed in the data word. A store to the data word is dropped while a byte is still going out. The receiver drops a start edge that does not last to the middle of the bit, and it drops a frame whose stop bit reads low.

Top module: `pulse_uart`

## Requirements
- R1: The register word is chosen by the byte address shifted right by two. Word 0 is the data register and word 1 is the divisor register. Address bits [1:0] do not affect the decode.
- R2: After reset, both words read as zero, `tx_out` is high, and `tx_irq` and `rx_irq` are low.
- R3: A store to word 1 keeps all 32 bits, and a load from word 1 returns them unchanged.
- R4: A load from any word index other than 0 or 1 returns zero. A store to such a word changes no register and starts no transmission.
- R5: A store to word 0 while the transmitter is idle sends a frame on `tx_out`: one low start bit, then bits [7:0] of the store with the LSB first, then one high stop bit. Each bit lasts 16*(divisor+1) clocks. The line stays high when idle.
- R6: `tx_irq` goes high for exactly one clock per sent byte. The pulse comes after the stop bit has completed, never at the store.
- R7: A store to word 0 while a frame is still being sent is ignored. The frame in flight keeps its byte, and no second frame or second `tx_irq` pulse follows.
- R8: A store to word 0 does not change what a load from word 0 returns. A load returns the last received byte, zero-extended to 32 bits.
- R9: A valid frame on `rx_in` (same format and bit time as R5) stores its byte in word 0, zero-extended. `rx_irq` goes high for exactly one clock for that frame.
- R10: The receiver passes `rx_in` through two flip-flops. A low level that has gone high again by the middle of the start bit is rejected: word 0 does not change and no `rx_irq` pulse follows.
- R11: A frame whose stop bit samples low is discarded: word 0 does not change and no `rx_irq` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Store strobe, one clock per store |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data for `bus_addr`, combinational |
| rx_in | input | 1 | Serial receive line, asynchronous |
| tx_out | output | 1 | Serial transmit line |
| tx_irq | output | 1 | One-clock pulse when a sent frame is complete |
| rx_irq | output | 1 | One-clock pulse when a received byte is stored |

## Verification
The assertions assume that `bus_wr` is a clean one-clock strobe with a stable address. They also assume the divisor is not rewritten while a frame is in flight in either direction. The stimulus sets the divisor only while both lines are idle, and the sweep covers divisor values 0 to 2. The receive frames come from the bench at the bit time it computes from the divisor, and every frame starts with the line already idle and high. That keeps the receiver's mid-bit sampling within its timing margin. The only deliberate breaks in the format are a short glitch and a low stop bit.

// File: rtl/pulse_uart_pkg.sv
package pulse_uart_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        TX_IDLE,
        TX_RUN
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] rxbyte;
        logic [WORD_W-1:0] div;
    } regs_t;

endpackage

// File: rtl/pulse_uart_tick.sv
module pulse_uart_tick #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] div,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_st_t;

    tick_st_t s_d, s_q;

    assign tick = (s_q.cnt == div);

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pulse_uart_tx.sv
module pulse_uart_tx
    import pulse_uart_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DATA_BITS-1:0] din,
    input  logic                 tick,
    output logic                 busy,
    output logic                 txd,
    output logic                 done
);

    localparam int OVS_W  = $clog2(OVS);
    localparam int LAST   = DATA_BITS + 1;
    localparam int BITN_W = $clog2(LAST + 1);
    localparam int IDX_W  = $clog2(DATA_BITS);

    typedef struct packed {
        tx_state_e            state;
        logic [DATA_BITS-1:0] data;
        logic [BITN_W-1:0]    bitn;
        logic [OVS_W-1:0]     ovs;
        logic                 txd;
        logic                 done;
    } tx_st_t;

    tx_st_t t_d, t_q;

    assign busy = (t_q.state == TX_RUN);
    assign txd  = t_q.txd;
    assign done = t_q.done;

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        unique case (t_q.state)
            TX_IDLE: begin
                t_d.txd = 1'b1;
                if (start) begin
                    t_d.state = TX_RUN;
                    t_d.data  = din;
                    t_d.bitn  = '0;
                    t_d.ovs   = '0;
                    t_d.txd   = 1'b0;
                end
            end
            TX_RUN: begin
                if (tick) begin
                    if (t_q.ovs == OVS_W'(OVS - 1)) begin
                        t_d.ovs = '0;
                        if (t_q.bitn == BITN_W'(LAST)) begin
                            t_d.state = TX_IDLE;
                            t_d.done  = 1'b1;
                            t_d.txd   = 1'b1;
                        end else begin
                            t_d.bitn = t_q.bitn + 1'b1;
                            if (t_q.bitn < BITN_W'(DATA_BITS)) begin
                                t_d.txd = t_q.data[t_q.bitn[IDX_W-1:0]];
                            end else begin
                                t_d.txd = 1'b1;
                            end
                        end
                    end else begin
                        t_d.ovs = t_q.ovs + 1'b1;
                    end
                end
            end
            default: t_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q       <= '0;
            t_q.state <= TX_IDLE;
            t_q.txd   <= 1'b1;
        end else begin
            t_q <= t_d;
        end
    end

    // R5: a frame opens with a low start bit on the line
    p_start_bit_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.state == TX_IDLE && start) |=> !txd);

    // R6: completion pulse is a single clock
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: completion happens with the line back at its idle level
    p_done_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (txd && !busy));

    // R7: a request during a frame leaves the byte in flight untouched
    p_busy_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(t_q.data));

endmodule

// File: rtl/pulse_uart_rx.sv
module pulse_uart_rx
    import pulse_uart_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_in,
    input  logic                 tick,
    output logic                 idle,
    output logic                 valid,
    output logic [DATA_BITS-1:0] dout
);

    localparam int OVS_W  = $clog2(OVS);
    localparam int HALF   = OVS / 2;
    localparam int BITN_W = $clog2(DATA_BITS);

    typedef struct packed {
        logic                 s1;
        logic                 s2;
        rx_state_e            state;
        logic [DATA_BITS-1:0] shreg;
        logic [BITN_W-1:0]    bitn;
        logic [OVS_W-1:0]     ovs;
        logic                 valid;
        logic [DATA_BITS-1:0] dout;
    } rx_st_t;

    rx_st_t r_d, r_q;

    assign idle  = (r_q.state == RX_IDLE);
    assign valid = r_q.valid;
    assign dout  = r_q.dout;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.s1    = rx_in;
        r_d.s2    = r_q.s1;
        unique case (r_q.state)
            RX_IDLE: begin
                if (!r_q.s2) begin
                    r_d.state = RX_START;
                    r_d.ovs   = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (r_q.ovs == OVS_W'(HALF - 1)) begin
                        r_d.ovs  = '0;
                        r_d.bitn = '0;
                        r_d.state = r_q.s2 ? RX_IDLE : RX_DATA;
                    end else begin
                        r_d.ovs = r_q.ovs + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (r_q.ovs == OVS_W'(OVS - 1)) begin
                        r_d.ovs   = '0;
                        r_d.shreg = {r_q.s2, r_q.shreg[DATA_BITS-1:1]};
                        if (r_q.bitn == BITN_W'(DATA_BITS - 1)) begin
                            r_d.state = RX_STOP;
                        end else begin
                            r_d.bitn = r_q.bitn + 1'b1;
                        end
                    end else begin
                        r_d.ovs = r_q.ovs + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (r_q.ovs == OVS_W'(OVS - 1)) begin
                        r_d.ovs   = '0;
                        r_d.state = RX_IDLE;
                        if (r_q.s2) begin
                            r_d.valid = 1'b1;
                            r_d.dout  = r_q.shreg;
                        end
                    end else begin
                        r_d.ovs = r_q.ovs + 1'b1;
                    end
                end
            end
            default: r_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.s1    <= 1'b1;
            r_q.s2    <= 1'b1;
            r_q.state <= RX_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R9: byte-ready pulse lasts one clock
    p_rx_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R10: a start level gone high at mid-bit sends the receiver back to idle
    p_glitch_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == RX_START && tick && r_q.ovs == OVS_W'(HALF - 1) && r_q.s2)
        |=> (idle && !valid));

    // R11: a low stop sample yields no byte
    p_frame_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == RX_STOP && tick && r_q.ovs == OVS_W'(OVS - 1) && !r_q.s2)
        |=> !valid);

endmodule

// File: rtl/pulse_uart.sv
module pulse_uart
    import pulse_uart_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              rx_in,
    output logic              tx_out,
    output logic              tx_irq,
    output logic              rx_irq
);

    localparam logic [ADDR_W-1:0] IDX_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] IDX_DIV  = ADDR_W'(1);

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] word_idx;
    logic              sel_data;
    logic              sel_div;
    logic              tx_start;
    logic              tx_busy;
    logic              tx_tick;
    logic              rx_tick;
    logic              rx_idle;
    logic              rx_valid;
    logic [BYTE_W-1:0] rx_byte;

    assign word_idx = bus_addr >> 2;
    assign sel_data = (word_idx == IDX_DATA);
    assign sel_div  = (word_idx == IDX_DIV);
    assign tx_start = bus_wr && sel_data && !tx_busy;

    always_comb begin
        r_d = r_q;
        if (bus_wr && sel_div) begin
            r_d.div = bus_wdata;
        end
        if (rx_valid) begin
            r_d.rxbyte = rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (sel_data) begin
            bus_rdata = {{(WORD_W - BYTE_W){1'b0}}, r_q.rxbyte};
        end else if (sel_div) begin
            bus_rdata = r_q.div;
        end else begin
            bus_rdata = '0;
        end
    end

    pulse_uart_tick #(.CNT_W(WORD_W)) u_tx_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!tx_busy),
        .div  (r_q.div),
        .tick (tx_tick)
    );

    pulse_uart_tick #(.CNT_W(WORD_W)) u_rx_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (rx_idle),
        .div  (r_q.div),
        .tick (rx_tick)
    );

    pulse_uart_tx #(.DATA_BITS(BYTE_W), .OVS(OVS)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tx_start),
        .din  (bus_wdata[BYTE_W-1:0]),
        .tick (tx_tick),
        .busy (tx_busy),
        .txd  (tx_out),
        .done (tx_irq)
    );

    pulse_uart_rx #(.DATA_BITS(BYTE_W), .OVS(OVS)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .rx_in(rx_in),
        .tick (rx_tick),
        .idle (rx_idle),
        .valid(rx_valid),
        .dout (rx_byte)
    );

    assign rx_irq = rx_valid;

    // R3: divisor store keeps the full word
    p_div_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_div) |=> (r_q.div == $past(bus_wdata)));

    // R4: loads outside the two words read zero
    p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_data && !sel_div) |-> (bus_rdata == '0));

    // R4: stores outside the two words leave both registers alone
    p_unmapped_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !sel_data && !sel_div && !rx_valid) |=> $stable(r_q));

    // R8: a data store never changes the received byte
    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_data && !rx_valid) |=> $stable(r_q.rxbyte));

endmodule

// File: tb/pulse_uart_bench.sv
module pulse_uart_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              rx_in = 1'b1;
    logic              tx_out;
    logic              tx_irq;
    logic              rx_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int tx_hi = 0;
    int rx_hi = 0;
    logic [7:0] last_rx = 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pulse_uart #(.ADDR_W(ADDR_W), .OVS(16)) u_pulse_uart (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .rx_in    (rx_in),
        .tx_out   (tx_out),
        .tx_irq   (tx_irq),
        .rx_irq   (rx_irq)
    );

    always @(posedge clk) begin
        if (tx_irq) tx_hi <= tx_hi + 1;
        if (rx_irq) rx_hi <= rx_hi + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Watch tx_out for one frame; the store has already been issued.
    task automatic tx_frame(input logic [7:0] b, input int dv, input int irq0, input string req);
        int bitclk;
        int t;
        logic [7:0] got;
        bitclk = 16 * (dv + 1);
        t = 0;
        while (tx_out === 1'b1 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (bitclk / 2) @(negedge clk);
        check({req, " R5 start bit low"}, {31'b0, tx_out}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            repeat (bitclk) @(negedge clk);
            got[i] = tx_out;
        end
        check({req, " R5 data bits LSB first"}, {24'b0, got}, {24'b0, b});
        repeat (bitclk) @(negedge clk);
        check({req, " R5 stop bit high"}, {31'b0, tx_out}, 32'd1);
        check({req, " R6 no tx_irq before stop ends"}, tx_hi, irq0);
        repeat (bitclk / 2 + 4) @(negedge clk);
        check({req, " R6 one tx_irq clock per byte"}, tx_hi, irq0 + 1);
    endtask

    task automatic rx_frame(input logic [7:0] b, input int dv, input logic stop);
        int bitclk;
        bitclk = 16 * (dv + 1);
        @(negedge clk);
        rx_in = 1'b0;
        repeat (bitclk) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = b[i];
            repeat (bitclk) @(negedge clk);
        end
        rx_in = stop;
        repeat (bitclk) @(negedge clk);
        rx_in = 1'b1;
        repeat (2 * bitclk) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        logic [7:0] txv [6];
        logic [7:0] rxv [5];
        int c0;
        int bitclk;
        logic stayed;
        txv = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80};
        rxv = '{8'h5A, 8'hFF, 8'h00, 8'hC3, 8'h81};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_read(4'h0, rd);
        check("R2 data reads zero after reset", rd, 32'h0);
        bus_read(4'h4, rd);
        check("R2 divisor reads zero after reset", rd, 32'h0);
        check("R2 tx line high after reset", {31'b0, tx_out}, 32'd1);
        check("R2 no interrupt after reset", {30'b0, tx_irq, rx_irq}, 32'd0);

        bus_write(4'h4, 32'h8000_0001);
        bus_read(4'h4, rd);
        check("R3 divisor full word", rd, 32'h8000_0001);
        bus_write(4'h4, 32'h1234_5678);
        bus_read(4'h7, rd);
        check("R1 R3 divisor at offset 7", rd, 32'h1234_5678);

        for (int dv = 0; dv < 3; dv++) begin
            bitclk = 16 * (dv + 1);
            // R1: low address bits ignored on the store
            bus_write(4'h6, dv);
            bus_read(4'h4, rd);
            check("R1 divisor store through offset 6", rd, dv);

            for (int k = 0; k < 5; k++) begin
                c0 = rx_hi;
                rx_frame(rxv[k] ^ 8'(dv), dv, 1'b1);
                last_rx = rxv[k] ^ 8'(dv);
                check("R9 one rx_irq clock per frame", rx_hi, c0 + 1);
                bus_read(4'h1, rd);
                check("R9 R1 received byte zero-extended", rd, {24'b0, last_rx});
            end

            // R10: glitch on the start bit
            c0 = rx_hi;
            @(negedge clk);
            rx_in = 1'b0;
            repeat (3) @(negedge clk);
            rx_in = 1'b1;
            repeat (2 * bitclk) @(negedge clk);
            check("R10 glitch gives no rx_irq", rx_hi, c0);
            bus_read(4'h0, rd);
            check("R10 glitch leaves data", rd, {24'b0, last_rx});

            // R11: low stop bit
            c0 = rx_hi;
            rx_frame(8'h77, dv, 1'b0);
            check("R11 bad stop gives no rx_irq", rx_hi, c0);
            bus_read(4'h0, rd);
            check("R11 bad stop leaves data", rd, {24'b0, last_rx});

            for (int k = 0; k < 6; k++) begin
                c0 = tx_hi;
                bus_write(4'h0, 32'hDEAD_BE00 | {24'b0, txv[k]});
                bus_read(4'h0, rd);
                check("R8 data store leaves readback", rd, {24'b0, last_rx});
                tx_frame(txv[k], dv, c0, "tx sweep");
            end

            // R7: second store while busy
            c0 = tx_hi;
            bus_write(4'h0, 32'h0000_0096);
            bus_write(4'h0, 32'h0000_0069);
            tx_frame(8'h96, dv, c0, "R7 overlap");
            stayed = 1'b1;
            for (int i = 0; i < bitclk * 2; i++) begin
                @(negedge clk);
                if (tx_out !== 1'b1) stayed = 1'b0;
            end
            check("R7 no second frame", {31'b0, stayed}, 32'd1);
            check("R7 no second tx_irq", tx_hi, c0 + 1);

            // R4: unmapped words
            c0 = tx_hi;
            bus_write(4'h8, 32'h0000_0055);
            bus_write(4'hC, 32'hFFFF_FFFF);
            bus_read(4'h8, rd);
            check("R4 unmapped read zero at 8", rd, 32'h0);
            bus_read(4'hD, rd);
            check("R4 unmapped read zero at D", rd, 32'h0);
            bus_read(4'h4, rd);
            check("R4 divisor kept after unmapped store", rd, dv);
            bus_read(4'h0, rd);
            check("R4 data kept after unmapped store", rd, {24'b0, last_rx});
            stayed = 1'b1;
            for (int i = 0; i < bitclk; i++) begin
                @(negedge clk);
                if (tx_out !== 1'b1) stayed = 1'b0;
            end
            check("R4 unmapped store sends nothing", {31'b0, stayed}, 32'd1);
            check("R4 unmapped store no tx_irq", tx_hi, c0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule